// File: doc/BRIEF.md
# Parallel Port Register Decoder

This block sits between an ISA-style host I/O bus and the register files of an extended-capabilities parallel port. On each host read or write it maps the address offset from the port base, together with the 3-bit operating mode, onto exactly one register select. The 3-bit mode comes from the extended control register, which is held elsewhere. The block turns that select into a one-cycle read or write strobe toward the FIFO, configuration and control logic. It also returns read data on the host bus.

The block owns only the printer data register. That register is written from the host bus and drives the data pins. A host read of the data port returns the levels seen on the pins. The block also produces the data-pin output enable and the two host-driven control lines. It keeps the host off the shared data bus whenever the peripheral is allowed to drive it.

The host strobes `io_wr` and `io_rd` are treated as levels. An access is the clock cycle in which one of them rises. `aen` high marks a DMA cycle, and every register ignores the bus during it.

Top module: `pport_regdec`

## Requirements
- R1: At offset 0x000, modes 000 and 001 select the data register (strobe bit 0), and mode 011 selects the address FIFO (bit 1).
- R2: In all eight modes, offset 0x001 selects status (bit 2), 0x002 selects control (bit 3) and 0x402 selects the extended control register (bit 9). A read of a register other than the data port returns `ext_rdata`.
- R3: Offset 0x400 selects the plain data FIFO in mode 010 (bit 4), the ECP data FIFO in mode 011 (bit 5) and the test FIFO in mode 110 (bit 6). In mode 111 it selects configuration A (bit 7), which gets read strobes only. A write to it gives no strobe.
- R4: Offset 0x401 selects configuration B (bit 8) in mode 111 only.
- R5: Any other offset and mode pair gives no strobe and leaves the data register unchanged. A read of it returns 0xFF.
- R6: While `aen` is high, no strobe fires, the data register keeps its value and reads return 0xFF.
- R7: A strobe is high for only the cycle in which `io_wr` or `io_rd` rises, and at most one bit is set. A level held high for longer gives no further strobe.
- R8: Reset clears the data register, so `pd_out` is 0x00.
- R9: A data register write appears non-inverted on `pd_out` from the next clock edge.
- R10: A data register read returns `pd_in`, not the latched value.
- R11: In mode 011, `pd_oe` is low in the same cycle that `n_init` and `host_ack` are both low. Otherwise mode 011 leaves `pd_oe` high.
- R12: In mode 001, `pd_oe` is the inverse of `dcr_dir`. In modes 000, 010 and 110, `pd_oe` is high.
- R13: `n_init` follows `ctl_init_n`. `n_select_in` is forced high in mode 011 and follows `ctl_selin_n` in every other mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| aen | input | 1 | DMA cycle marker; high blocks all accesses |
| ofs | input | 11 | Address offset from the port base |
| io_wr | input | 1 | Host write level |
| io_rd | input | 1 | Host read level |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Host read data |
| mode | input | 3 | Operating mode from the extended control register |
| ext_rdata | input | 8 | Read data from the register owning the current select |
| wr_stb | output | 10 | One-hot write strobes |
| rd_stb | output | 10 | One-hot read strobes |
| pd_out | output | 8 | Data register value toward the pins |
| pd_in | input | 8 | Sampled pin levels |
| pd_oe | output | 1 | Host drive enable for the data pins |
| ctl_init_n | input | 1 | Requested direction/init line level |
| ctl_selin_n | input | 1 | Requested select line level |
| host_ack | input | 1 | Handshake level from the transfer logic |
| dcr_dir | input | 1 | Direction bit for bidirectional mode |
| n_init | output | 1 | Direction/init line to the cable |
| n_select_in | output | 1 | Select line to the cable |

## Verification
The hardest case to reach is the hand-over of the data bus. The enable must drop in the same cycle that the last reverse-direction condition appears, with no clock edge in between. The bench sets mode 011 and holds the init line low. It then lowers `host_ack` in the middle of a cycle and samples `pd_oe` one nanosecond later, before the next edge. It then raises `host_ack` again to confirm that the enable comes back. Held strobes, and writes during `aen`, are checked by reading back `pd_out`, because a write that should have been dropped would show there.

// File: rtl/pport_regdec.sv
module pport_regdec #(
  parameter int DW = 8,
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          aen,
  input  logic [AW-1:0] ofs,
  input  logic          io_wr,
  input  logic          io_rd,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic [2:0]    mode,
  input  logic [DW-1:0] ext_rdata,
  output logic [9:0]    wr_stb,
  output logic [9:0]    rd_stb,
  output logic [DW-1:0] pd_out,
  input  logic [DW-1:0] pd_in,
  output logic          pd_oe,
  input  logic          ctl_init_n,
  input  logic          ctl_selin_n,
  input  logic          host_ack,
  input  logic          dcr_dir,
  output logic          n_init,
  output logic          n_select_in
);
  localparam int S_DATA = 0, S_AFIFO = 1, S_STAT = 2, S_CTRL = 3, S_PFIFO = 4;
  localparam int S_DFIFO = 5, S_TFIFO = 6, S_CFGA = 7, S_CFGB = 8, S_ECR = 9;
  localparam logic [AW-1:0] OFS_HI   = AW'(1) << (AW - 1);
  localparam logic [AW-1:0] OFS_DATA = '0;
  localparam logic [AW-1:0] OFS_STAT = AW'(1);
  localparam logic [AW-1:0] OFS_CTRL = AW'(2);
  localparam logic [AW-1:0] OFS_FIFO = OFS_HI;
  localparam logic [AW-1:0] OFS_CFGB = OFS_HI + AW'(1);
  localparam logic [AW-1:0] OFS_ECR  = OFS_HI + AW'(2);
  localparam logic [9:0]    RO_MASK  = 10'(1) << S_CFGA;

  logic [9:0]    sel;
  logic          wr_q, rd_q;
  logic [DW-1:0] data_q;
  logic          ecp, rev;

  always_comb begin
    sel = '0;
    case (ofs)
      OFS_DATA: begin
        if (mode == 3'b000 || mode == 3'b001) sel[S_DATA] = 1'b1;
        else if (mode == 3'b011)              sel[S_AFIFO] = 1'b1;
      end
      OFS_STAT: sel[S_STAT] = 1'b1;
      OFS_CTRL: sel[S_CTRL] = 1'b1;
      OFS_FIFO: begin
        case (mode)
          3'b010:  sel[S_PFIFO] = 1'b1;
          3'b011:  sel[S_DFIFO] = 1'b1;
          3'b110:  sel[S_TFIFO] = 1'b1;
          3'b111:  sel[S_CFGA]  = 1'b1;
          default: sel = '0;
        endcase
      end
      OFS_CFGB: if (mode == 3'b111) sel[S_CFGB] = 1'b1;
      OFS_ECR:  sel[S_ECR] = 1'b1;
      default:  sel = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q   <= 1'b0;
      rd_q   <= 1'b0;
      data_q <= '0;
    end else begin
      wr_q <= io_wr;
      rd_q <= io_rd;
      if (wr_stb[S_DATA]) data_q <= wdata;
    end
  end

  assign wr_stb = (io_wr && !wr_q && !aen) ? (sel & ~RO_MASK) : '0;
  assign rd_stb = (io_rd && !rd_q && !aen) ? sel : '0;
  assign rdata  = (aen || sel == '0) ? '1 : (sel[S_DATA] ? pd_in : ext_rdata);
  assign pd_out = data_q;

  assign ecp         = (mode == 3'b011);
  assign n_init      = ctl_init_n;
  assign n_select_in = ecp ? 1'b1 : ctl_selin_n;
  assign rev         = ecp && !ctl_init_n && !host_ack;
  assign pd_oe       = !(rev || (mode == 3'b001 && dcr_dir));

  // R6
  aen_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    aen |-> (wr_stb == '0 && rd_stb == '0));
  // R7
  stb_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_stb) && $onehot0(rd_stb));
  // R7
  wr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb != '0) |=> (wr_stb == '0));
  // R9
  data_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb[S_DATA] |=> (pd_out == $past(wdata)));
  // R10
  data_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb[S_DATA] |-> (rdata == pd_in));
  // R11
  no_contend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ecp && !n_init && !host_ack) |-> !pd_oe);
  // R13
  ecp_selin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ecp |-> n_select_in);
endmodule

// File: tb/pport_regdec_test.sv
module pport_regdec_test;
  logic        clk = 0, rst_n = 0, aen = 0, io_wr = 0, io_rd = 0;
  logic [10:0] ofs = '0;
  logic [7:0]  wdata = '0, ext_rdata = 8'h77, pd_in = '0;
  logic [2:0]  mode = '0;
  logic        ctl_init_n = 1, ctl_selin_n = 1, host_ack = 1, dcr_dir = 0;
  logic [7:0]  rdata, pd_out;
  logic [9:0]  wr_stb, rd_stb;
  logic        pd_oe, n_init, n_select_in;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  pport_regdec uut (.*);

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [9:0] vec(input int idx);
    return (idx < 0) ? 10'd0 : (10'd1 << idx);
  endfunction

  task automatic wr_acc(input logic [10:0] o, input logic [7:0] d, input int idx, input string tag);
    @(negedge clk); ofs = o; wdata = d; io_wr = 1; #1;
    chk(wr_stb == vec(idx) && rd_stb == 0, tag, 32'(wr_stb), 32'(vec(idx)));
    @(negedge clk); io_wr = 0;
  endtask

  task automatic rd_acc(input logic [10:0] o, input int idx, input logic [7:0] exp, input string tag);
    @(negedge clk); ofs = o; io_rd = 1; #1;
    chk(rd_stb == vec(idx) && wr_stb == 0, tag, 32'(rd_stb), 32'(vec(idx)));
    chk(rdata == exp, tag, 32'(rdata), 32'(exp));
    @(negedge clk); io_rd = 0;
  endtask

  task automatic t_reset;
    #1; chk(pd_out == 8'h00, "R8 reset data", 32'(pd_out), 0);
    repeat (3) @(negedge clk); rst_n = 1;
    chk(pd_out == 8'h00, "R8 after reset", 32'(pd_out), 0);
  endtask

  task automatic t_data;
    mode = 3'b000; wr_acc(11'h000, 8'hA5, 0, "R1 data wr m0");
    chk(pd_out == 8'hA5, "R9 pd_out", 32'(pd_out), 32'hA5);
    pd_in = 8'h3C; rd_acc(11'h000, 0, 8'h3C, "R10 data rd pins");
    mode = 3'b001; wr_acc(11'h000, 8'h5A, 0, "R1 data wr m1");
    chk(pd_out == 8'h5A, "R9 pd_out m1", 32'(pd_out), 32'h5A);
    mode = 3'b011; wr_acc(11'h000, 8'hC3, 1, "R1 afifo m3");
    chk(pd_out == 8'h5A, "R1 afifo leaves data", 32'(pd_out), 32'h5A);
  endtask

  task automatic t_allmodes;
    for (int m = 0; m < 8; m++) begin
      mode = 3'(m);
      rd_acc(11'h001, 2, 8'h77, "R2 status");
      wr_acc(11'h002, 8'h01, 3, "R2 control");
      wr_acc(11'h402, 8'h02, 9, "R2 ecr");
    end
  endtask

  task automatic t_fifo;
    mode = 3'b010; wr_acc(11'h400, 8'h10, 4, "R3 pfifo");
    mode = 3'b011; wr_acc(11'h400, 8'h11, 5, "R3 dfifo");
    mode = 3'b110; wr_acc(11'h400, 8'h12, 6, "R3 tfifo");
    mode = 3'b111; rd_acc(11'h400, 7, 8'h77, "R3 cfgA rd");
    wr_acc(11'h400, 8'h13, -1, "R3 cfgA wr blocked");
    rd_acc(11'h401, 8, 8'h77, "R4 cfgB m7");
    mode = 3'b011; rd_acc(11'h401, -1, 8'hFF, "R4 cfgB other mode");
  endtask

  task automatic t_unmapped;
    mode = 3'b000; rd_acc(11'h400, -1, 8'hFF, "R5 400 in m0");
    mode = 3'b010; wr_acc(11'h000, 8'h99, -1, "R5 data in m2");
    chk(pd_out == 8'h5A, "R5 data kept", 32'(pd_out), 32'h5A);
    mode = 3'b100; rd_acc(11'h000, -1, 8'hFF, "R5 data in m4");
    mode = 3'b000; rd_acc(11'h123, -1, 8'hFF, "R5 odd offset");
  endtask

  task automatic t_aen;
    mode = 3'b000; aen = 1;
    wr_acc(11'h000, 8'h11, -1, "R6 aen write");
    chk(pd_out == 8'h5A, "R6 data kept", 32'(pd_out), 32'h5A);
    rd_acc(11'h001, -1, 8'hFF, "R6 aen read");
    aen = 0;
  endtask

  task automatic t_edge;
    mode = 3'b000;
    @(negedge clk); ofs = 11'h000; wdata = 8'h42; io_wr = 1; #1;
    chk(wr_stb == vec(0), "R7 first cycle", 32'(wr_stb), 1);
    @(negedge clk); wdata = 8'h24; #1;
    chk(wr_stb == 0, "R7 held level", 32'(wr_stb), 0);
    @(negedge clk); io_wr = 0;
    chk(pd_out == 8'h42, "R7 no second capture", 32'(pd_out), 32'h42);
  endtask

  task automatic t_dir;
    @(negedge clk); mode = 3'b011; ctl_init_n = 0; host_ack = 1; #1;
    chk(pd_oe == 1, "R11 ack high", 32'(pd_oe), 1);
    @(negedge clk); host_ack = 0; #1;
    chk(pd_oe == 0, "R11 reverse same cycle", 32'(pd_oe), 0);
    host_ack = 1; #1;
    chk(pd_oe == 1, "R11 release", 32'(pd_oe), 1);
    host_ack = 0; mode = 3'b000; #1;
    chk(pd_oe == 1, "R12 m0 forward", 32'(pd_oe), 1);
    mode = 3'b001; dcr_dir = 1; #1;
    chk(pd_oe == 0, "R12 m1 dir set", 32'(pd_oe), 0);
    dcr_dir = 0; #1;
    chk(pd_oe == 1, "R12 m1 dir clear", 32'(pd_oe), 1);
    chk(n_init == 0, "R13 init follows", 32'(n_init), 0);
    mode = 3'b011; ctl_selin_n = 0; #1;
    chk(n_select_in == 1, "R13 selin forced", 32'(n_select_in), 1);
    mode = 3'b000; #1;
    chk(n_select_in == 0, "R13 selin follows", 32'(n_select_in), 0);
    ctl_init_n = 1; #1;
    chk(n_init == 1, "R13 init high", 32'(n_init), 1);
  endtask

  initial begin
    t_reset; t_data; t_allmodes; t_fifo; t_unmapped; t_aen; t_edge; t_dir;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #400000;
    checks++; fails++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule